// File: doc/BRIEF.md
# Grid/Internal Reference Angle Selector

This block chooses the phase angle that the inverter control loops use as their reference. While the inverter is tied to the grid, the block passes the angle from the phase-locked loop straight through. It also keeps an internal phase generator continuously loaded with that angle.

When an islanding request arrives, the internal generator is released. From then on it advances by a programmable rated-frequency increment on every sample strobe. It starts from the last loop angle it captured, and the output switches to it.

A later return request does not switch back at once. The block waits until the internal angle and the loop angle agree to within a programmable threshold, measured around the circle. Only then does it hand the output back to the loop angle. This avoids a phase step at reconnection.

Angles are unsigned 16-bit fractions of one turn, so 0x0000 means 0 and 0x8000 means half a turn. The block is controlled by a three-state machine:

- `ST_GRID` (track): the output is the loop angle.
- `ST_ISLAND` (free-run): the output is the internal angle.
- `ST_RESYNC` (waiting for coincidence): the output is the internal angle.

The transitions are named as follows. Every transition happens only on a clock edge where `sample_en` is high.

- GO_ISLAND: `ST_GRID` to `ST_ISLAND`, taken on `island_req`.
- GO_RESYNC: `ST_ISLAND` to `ST_RESYNC`, taken on `return_req`.
- ABORT_RETURN: `ST_RESYNC` to `ST_ISLAND`, taken on `island_req`. It has priority over RECONNECT.
- RECONNECT: `ST_RESYNC` to `ST_GRID`, taken when the circular distance is below the threshold.

Top module: `ref_angle_sel`

## Requirements
- R1: After reset the block is in `ST_GRID`, with `use_internal`=0, `wait_sync`=0 and `ref_angle` equal to `pll_angle`.
- R2: In `ST_GRID`, `ref_angle` equals `pll_angle` in the same cycle.
- R3: In `ST_GRID`, a sample-strobe edge with `island_req`=1 enters `ST_ISLAND`. The internal angle is loaded with `pll_angle` at that edge, and from the next cycle `ref_angle` shows that value with `use_internal`=1.
- R4: While the internal source is selected, each sample-strobe edge adds `rated_inc` to the internal angle modulo 2^16, with wrap-around. The internal angle does not depend on `pll_angle`.
- R5: In `ST_ISLAND`, a sample-strobe edge with `return_req`=1 enters `ST_RESYNC`. This sets `wait_sync`=1 while the output stays on the internal angle.
- R6: In `ST_RESYNC`, a sample-strobe edge moves to `ST_GRID` only when the circular distance between the internal angle and `pll_angle` before the edge is strictly less than `match_thr`. A distance equal to the threshold keeps the block waiting.
- R7: The distance is |(internal − pll) mod 2^16| taken as a signed 16-bit value. For example, 0x0020 and 0xFFE0 are 0x0040 apart.
- R8: In `ST_RESYNC`, `island_req`=1 on a sample-strobe edge returns the block to `ST_ISLAND`, even when the angles coincide. The internal angle keeps advancing without a jump.
- R9: On edges where `sample_en`=0, the state and the internal angle do not change, whatever the requests and the angles are.
- R10: `island_req` has no effect in `ST_ISLAND`, and `return_req` has no effect in `ST_GRID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample strobe: advances the generator and qualifies all transitions |
| pll_angle | input | 16 | Angle from the phase-locked loop, fraction of a turn |
| island_req | input | 1 | Command to enter free-running operation |
| return_req | input | 1 | Command to return to the loop angle |
| rated_inc | input | 16 | Per-sample phase increment at rated frequency |
| match_thr | input | 16 | Coincidence threshold for reconnection |
| ref_angle | output | 16 | Selected reference angle |
| use_internal | output | 1 | 1 when the internal generator drives `ref_angle` |
| wait_sync | output | 1 | 1 while waiting for angle coincidence |

## Verification
The bench places the loop angle exactly one threshold away from the internal angle. A design that compares with less-or-equal would reconnect one sample early there.

It then puts the two angles on opposite sides of the zero crossing. A design that takes a plain unsigned difference would see a distance of nearly a full turn and never reconnect.

It raises an islanding request while the angles coincide during resync. This catches a design that gives reconnection priority, and one that reloads the generator when resuming free-run.

It also holds the strobe low while requests are pending and the angles match. A design that moves or changes state off the strobe is exposed there, as is one whose generator wrap-around is mishandled.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        ST_GRID   = 2'd0,
        ST_ISLAND = 2'd1,
        ST_RESYNC = 2'd2
    } ras_state_t;

endpackage

// File: rtl/ras_phase_gen.sv
module ras_phase_gen #(
    parameter int ANG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             track,
    input  logic [ANG_W-1:0] pll_angle,
    input  logic [ANG_W-1:0] inc,
    output logic [ANG_W-1:0] angle
);

    logic [ANG_W-1:0] acc_q;

    // Loaded from the loop angle while tracking, otherwise a wrapping accumulator.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_en) begin
            if (track) begin
                acc_q <= pll_angle;
            end else begin
                acc_q <= acc_q + inc;
            end
        end
    end

    assign angle = acc_q;

endmodule

// File: rtl/ras_angle_cmp.sv
module ras_angle_cmp #(
    parameter int ANG_W = 16
) (
    input  logic [ANG_W-1:0] ang_a,
    input  logic [ANG_W-1:0] ang_b,
    input  logic [ANG_W-1:0] thr,
    output logic             near
);

    localparam int SIGN_BIT = ANG_W - 1;

    logic [ANG_W-1:0] diff;
    logic [ANG_W-1:0] mag;

    always_comb begin
        diff = ang_a - ang_b;
        // Negating the most negative value yields its correct unsigned magnitude.
        if (diff[SIGN_BIT]) begin
            mag = ~diff + 1'b1;
        end else begin
            mag = diff;
        end
        near = (mag < thr);
    end

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       island_req,
    input  logic       return_req,
    input  logic       near,
    output ras_state_t state,
    output logic       track,
    output logic       use_internal,
    output logic       wait_sync
);

    ras_state_t state_q;
    ras_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (sample_en) begin
            unique case (state_q)
                ST_GRID: begin
                    if (island_req) state_d = ST_ISLAND;
                end
                ST_ISLAND: begin
                    if (return_req) state_d = ST_RESYNC;
                end
                ST_RESYNC: begin
                    if (island_req)  state_d = ST_ISLAND;
                    else if (near)   state_d = ST_GRID;
                end
                default: state_d = ST_GRID;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GRID;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        track        = 1'b0;
        use_internal = 1'b1;
        wait_sync    = 1'b0;
        unique case (state_q)
            ST_GRID: begin
                track        = 1'b1;
                use_internal = 1'b0;
            end
            ST_ISLAND: begin
                use_internal = 1'b1;
            end
            ST_RESYNC: begin
                wait_sync    = 1'b1;
            end
            default: begin
                track        = 1'b1;
                use_internal = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/ref_angle_sel.sv
module ref_angle_sel
    import ras_pkg::*;
#(
    parameter int ANG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [ANG_W-1:0] pll_angle,
    input  logic             island_req,
    input  logic             return_req,
    input  logic [ANG_W-1:0] rated_inc,
    input  logic [ANG_W-1:0] match_thr,
    output logic [ANG_W-1:0] ref_angle,
    output logic             use_internal,
    output logic             wait_sync
);

    ras_state_t       state;
    logic             track;
    logic             near;
    logic [ANG_W-1:0] int_angle;

    ras_phase_gen #(.ANG_W(ANG_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (sample_en),
        .track     (track),
        .pll_angle (pll_angle),
        .inc       (rated_inc),
        .angle     (int_angle)
    );

    ras_angle_cmp #(.ANG_W(ANG_W)) u_cmp (
        .ang_a (int_angle),
        .ang_b (pll_angle),
        .thr   (match_thr),
        .near  (near)
    );

    ras_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .island_req   (island_req),
        .return_req   (return_req),
        .near         (near),
        .state        (state),
        .track        (track),
        .use_internal (use_internal),
        .wait_sync    (wait_sync)
    );

    // Reference switch.
    assign ref_angle = use_internal ? int_angle : pll_angle;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int ANG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_en,
    input logic [ANG_W-1:0] pll_angle,
    input logic             island_req,
    input logic             return_req,
    input logic [ANG_W-1:0] rated_inc,
    input logic [ANG_W-1:0] ref_angle,
    input logic             use_internal,
    input logic             wait_sync
);

    // R2: the grid state passes the loop angle through.
    p_grid_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !use_internal |-> (ref_angle == pll_angle));

    // R3: free-run starts from the captured loop angle.
    p_island_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_internal && sample_en && island_req)
        |=> (use_internal && ref_angle == $past(pll_angle)));

    // R4: the internal angle advances by one increment per strobe, with wrap.
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_internal && sample_en)
        |=> (!use_internal || ref_angle == ANG_W'($past(ref_angle) + $past(rated_inc))));

    // R5: waiting always keeps the internal source.
    p_wait_internal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_sync |-> use_internal);

    // R6: the switch back to the loop only happens out of the waiting state.
    p_reconnect_from_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(use_internal) |-> $past(wait_sync));

    // R9: nothing moves without a strobe.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(use_internal) && $stable(wait_sync)
                        && (!use_internal || $stable(ref_angle))));

    // R10: free-run persists unless a return is requested.
    p_island_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (use_internal && !wait_sync && sample_en && !return_req)
        |=> (use_internal && !wait_sync));

endmodule

bind ref_angle_sel ras_checker #(.ANG_W(ANG_W)) u_ras_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_en    (sample_en),
    .pll_angle    (pll_angle),
    .island_req   (island_req),
    .return_req   (return_req),
    .rated_inc    (rated_inc),
    .ref_angle    (ref_angle),
    .use_internal (use_internal),
    .wait_sync    (wait_sync)
);

// File: tb/sim_ref_angle_sel.sv
module sim_ref_angle_sel;

    typedef struct {
        logic [15:0] ang;
        logic        use_i;
        logic        wt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [15:0] pll_angle = 16'h1234;
    logic        island_req = 1'b0;
    logic        return_req = 1'b0;
    logic [15:0] rated_inc = 16'h0100;
    logic [15:0] match_thr = 16'h0100;
    logic [15:0] ref_angle;
    logic        use_internal;
    logic        wait_sync;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    ref_angle_sel u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .pll_angle    (pll_angle),
        .island_req   (island_req),
        .return_req   (return_req),
        .rated_inc    (rated_inc),
        .match_thr    (match_thr),
        .ref_angle    (ref_angle),
        .use_internal (use_internal),
        .wait_sync    (wait_sync)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (ref_angle !== e.ang || use_internal !== e.use_i || wait_sync !== e.wt) begin
            n_fail++;
            $display("FAIL %s: actual ang=%h use=%b wait=%b expected ang=%h use=%b wait=%b",
                     e.tag, ref_angle, use_internal, wait_sync, e.ang, e.use_i, e.wt);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs after the edge.
    task automatic step(input logic s, input logic [15:0] pa, input logic [15:0] inc,
                        input logic isl, input logic ret,
                        input logic [15:0] e_ang, input logic e_use, input logic e_wt,
                        input string tag);
        exp_t e;
        @(negedge clk);
        sample_en  = s;
        pll_angle  = pa;
        rated_inc  = inc;
        island_req = isl;
        return_req = ret;
        e.ang = e_ang; e.use_i = e_use; e.wt = e_wt; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares once the edge following each stimulus has settled.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #1;
        e.ang = 16'h1234; e.use_i = 1'b0; e.wt = 1'b0; e.tag = "R1 reset state";
        compare(e);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 16'h2000, 16'h0100, 0, 0, 16'h2000, 0, 0, "R2 grid passthrough");
        step(0, 16'h3000, 16'h0100, 1, 0, 16'h3000, 0, 0, "R9 island req without strobe");
        step(1, 16'h4000, 16'h0100, 0, 1, 16'h4000, 0, 0, "R10 return ignored in grid");
        step(1, 16'h5000, 16'h0100, 1, 0, 16'h5000, 1, 0, "R3 enter island from pll angle");
        step(1, 16'h9000, 16'h0100, 0, 0, 16'h5100, 1, 0, "R4 free-run advance");
        step(0, 16'h9100, 16'h0100, 0, 1, 16'h5100, 1, 0, "R9 hold without strobe");
        step(1, 16'h9200, 16'h0100, 1, 0, 16'h5200, 1, 0, "R10 island req ignored in island");
        step(1, 16'h9300, 16'h0100, 0, 1, 16'h5300, 1, 1, "R5 enter resync");
        step(1, 16'h5400, 16'h0100, 0, 0, 16'h5400, 1, 1, "R6 distance equal to threshold waits");
        step(0, 16'h5400, 16'h0100, 0, 0, 16'h5400, 1, 1, "R9 coincidence without strobe");
        step(1, 16'h54FF, 16'h0100, 1, 0, 16'h5500, 1, 0, "R8 abort return despite coincidence");
        step(1, 16'h0000, 16'h0100, 0, 1, 16'h5600, 1, 1, "R5 resync again");
        step(1, 16'h0000, 16'hA9F0, 0, 0, 16'hFFF0, 1, 1, "R6 far angle waits");
        step(1, 16'h8000, 16'h0030, 0, 0, 16'h0020, 1, 1, "R4 generator wraps");
        step(1, 16'hFFE0, 16'h0010, 0, 0, 16'hFFE0, 0, 0, "R7 reconnect across zero");
        step(1, 16'h7777, 16'h0010, 0, 0, 16'h7777, 0, 0, "R2 passthrough after reconnect");

        @(negedge clk);
        sample_en = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule